// File: doc/BRIEF.md
# GPIO Port Register Bank with Clear/Set/Toggle Aliases

This block is the software-visible register bank of a 16-bit general-purpose I/O port. A simple synchronous bus reaches it: each cycle a request carries a select, a write flag, a byte offset, an access size and 16 bits of write data. Read data and an error flag come back registered, one cycle after the request. The bank holds eight 16-bit registers: the pin data register, two interrupt mask registers (A and B), and the direction, polarity, edge-mode, both-edges and input-enable registers. Their current values are driven straight out, so the separate interrupt qualification block and the pad logic can use them.

The data register and both mask registers each sit at four consecutive word addresses: a plain address and three alias addresses. A write to an alias clears, sets or toggles only the bits where the written value has ones, so software can change single bits without a read-modify-write sequence. Reading any of the four addresses of such a group returns the register itself. Pin sampling from the pad side can also update the data register, but only on bits that are both inputs and input-enabled. When a bus write to the data register lands in the same cycle, the bus write wins on the bits it touches.

Top module: `gpio_rf_regfile`

## Requirements
- R1: After reset every register output is 0x0000, and `bus_rdata` and `bus_err` are 0.
- R2: A valid write to a plain address replaces that register with the write data. The map, at a 4-byte stride, is: 0x00 data, 0x10 mask A, 0x20 mask B, 0x30 direction, 0x34 polarity, 0x38 edge mode, 0x3C both-edges, 0x40 input enable.
- R3: A valid write to a clear alias (0x04 data, 0x14 mask A, 0x24 mask B) clears the register bits where the write data is 1 and keeps the others.
- R4: A valid write to a set alias (0x08 data, 0x18 mask A, 0x28 mask B) ORs the write data into the register.
- R5: A valid write to a toggle alias (0x0C data, 0x1C mask A, 0x2C mask B) XORs the write data into the register.
- R6: A valid read of any of the four addresses of the data, mask A or mask B group returns that group's current register value. A valid read of any other address returns that register's value.
- R7: A request is invalid if its offset is not a multiple of 4, if its offset is above 0x40, or if `bus_size` is not 2'b01 (16 bits). An invalid request sets `bus_err` to 1 in the next cycle with `bus_rdata` 0x0000, and it changes no register.
- R8: `bus_rdata` and `bus_err` are registered and belong to the request of the previous cycle. After a write or an idle cycle, `bus_rdata` is 0x0000.
- R9: When `pin_we` is 1, every data bit whose direction bit and input-enable bit are both 1 takes the value of `pin_in`. All other data bits keep their value.
- R10: When a valid bus write to the data group and a pin sample fall in the same cycle, the bus result wins on the bits the write touches (all bits for the plain address, the one-bits of the write data for an alias). The pin sample still applies to the other enabled bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Request valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset of the register |
| bus_size | input | 2 | Access size: 2'b00 byte, 2'b01 16-bit, 2'b10 32-bit |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_err | output | 1 | Registered invalid-access flag |
| pin_we | input | 1 | Pin sample strobe |
| pin_in | input | 16 | Sampled pin levels |
| data_q | output | 16 | Data register |
| maska_q | output | 16 | Interrupt mask A |
| maskb_q | output | 16 | Interrupt mask B |
| dir_q | output | 16 | Direction register (1 = input) |
| polar_q | output | 16 | Polarity register |
| edge_q | output | 16 | Edge-mode register |
| both_q | output | 16 | Both-edges register |
| inen_q | output | 16 | Input-enable register |

## Verification
The assertions assume that `bus_sel`, `bus_wr`, `bus_addr`, `bus_size` and `bus_wdata` are stable over each whole cycle, and that the mask and control registers change only through the bus. This holds because pin sampling reaches the data register alone. For that reason the alias properties are written on the mask registers and the direction register, which no other input can disturb. The stimulus changes all inputs just after the falling edge and holds them until the next one. Invalid requests are mixed with valid traffic, and pin samples that touch the data register are driven both alone and together with data-group writes.

// File: rtl/gpio_rf_pkg.sv
// Shared types and constants for the GPIO register bank.
// Assumes one 16-bit register per 4-byte word slot.
package gpio_rf_pkg;
    localparam int DW        = 16;
    localparam int NUM_REGS  = 8;
    localparam int NUM_SLOTS = 17;
    localparam int GRP_SLOTS = 12;   // slots carrying alias groups
    localparam logic [1:0] SIZE_HALF = 2'b01;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_CLR   = 2'd1,
        OP_SET   = 2'd2,
        OP_TGL   = 2'd3
    } alias_op_e;

    typedef enum logic [2:0] {
        SEL_DATA  = 3'd0,
        SEL_MASKA = 3'd1,
        SEL_MASKB = 3'd2,
        SEL_DIR   = 3'd3,
        SEL_POLAR = 3'd4,
        SEL_EDGE  = 3'd5,
        SEL_BOTH  = 3'd6,
        SEL_INEN  = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gpio_rf_decode.sv
// Address decoder: maps a byte offset and access size to a register
// select and an alias operation, and flags invalid requests.
// Assumes AW >= 7 so that the whole map fits.
module gpio_rf_decode
    import gpio_rf_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    output logic          ok,
    output reg_sel_e      sel,
    output alias_op_e     op
);
    localparam int SW = AW - 2;

    logic [SW-1:0] slot;
    assign slot = addr[AW-1:2];

    // Validity: word aligned, inside the map, 16-bit access.
    always_comb begin
        ok = (addr[1:0] == 2'b00) && (int'(slot) < NUM_SLOTS) && (size == SIZE_HALF);
    end

    // Slot to register/operation: groups of four, then plain registers.
    always_comb begin
        if (int'(slot) < GRP_SLOTS) begin
            sel = reg_sel_e'(slot[3:2]);
            op  = alias_op_e'(slot[1:0]);
        end else begin
            sel = reg_sel_e'(3'(slot - SW'(GRP_SLOTS - 3)));
            op  = OP_WRITE;
        end
    end
endmodule

// File: rtl/gpio_rf_alias_upd.sv
// Per-register write unit: computes the next value for a plain,
// clear, set or toggle write and the mask of bits the write touches.
// Assumes hit is low when no valid write targets this register.
module gpio_rf_alias_upd
    import gpio_rf_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] wdata,
    input  alias_op_e    op,
    input  logic         hit,
    output logic [W-1:0] nxt,
    output logic [W-1:0] touch
);
    // Apply the alias operation when this register is hit.
    always_comb begin
        nxt   = cur;
        touch = '0;
        if (hit) begin
            unique case (op)
                OP_WRITE: begin nxt = wdata;        touch = '1;    end
                OP_CLR:   begin nxt = cur & ~wdata; touch = wdata; end
                OP_SET:   begin nxt = cur | wdata;  touch = wdata; end
                OP_TGL:   begin nxt = cur ^ wdata;  touch = wdata; end
                default:  begin nxt = cur;          touch = '0;    end
            endcase
        end
    end
endmodule

// File: rtl/gpio_rf_regfile.sv
// GPIO port register bank: eight registers behind a 17-slot map, with
// clear/set/toggle aliases on data and both masks, pin sampling into
// data, and registered read data and error flag.
// Assumes bus inputs are synchronous to clk; reset is synchronous, active low.
module gpio_rf_regfile
    import gpio_rf_pkg::*;
#(
    parameter int AW = 7,
    parameter int W  = DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [1:0]    bus_size,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    output logic          bus_err,
    input  logic          pin_we,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  data_q,
    output logic [W-1:0]  maska_q,
    output logic [W-1:0]  maskb_q,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  polar_q,
    output logic [W-1:0]  edge_q,
    output logic [W-1:0]  both_q,
    output logic [W-1:0]  inen_q
);
    logic      dec_ok;
    reg_sel_e  dec_sel;
    alias_op_e dec_op;
    logic      wr_go;

    logic [W-1:0] regs_q [NUM_REGS];
    logic [W-1:0] regs_d [NUM_REGS];
    logic [W-1:0] upd_nxt [NUM_REGS];
    logic [W-1:0] upd_touch [NUM_REGS];
    logic [W-1:0] pin_en;

    gpio_rf_decode #(.AW(AW)) i_decode (
        .addr (bus_addr),
        .size (bus_size),
        .ok   (dec_ok),
        .sel  (dec_sel),
        .op   (dec_op)
    );

    assign wr_go  = bus_sel && bus_wr && dec_ok;
    assign pin_en = pin_we ? (regs_q[SEL_DIR] & regs_q[SEL_INEN]) : '0;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic hit;
        assign hit = wr_go && (dec_sel == reg_sel_e'(g));

        gpio_rf_alias_upd #(.W(W)) i_upd (
            .cur   (regs_q[g]),
            .wdata (bus_wdata),
            .op    (dec_op),
            .hit   (hit),
            .nxt   (upd_nxt[g]),
            .touch (upd_touch[g])
        );

        if (g == int'(SEL_DATA)) begin : g_pin_merge
            // Data: bus wins on touched bits, pins fill the other enabled bits.
            always_comb begin
                regs_d[g] = (upd_nxt[g] & upd_touch[g])
                          | (pin_in & pin_en & ~upd_touch[g])
                          | (regs_q[g] & ~upd_touch[g] & ~pin_en);
            end
        end else begin : g_plain
            // Other registers take the write unit result directly.
            always_comb begin
                regs_d[g] = upd_nxt[g];
            end
        end
    end

    // Register state update with synchronous reset.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            regs_q[i] <= rst_n ? regs_d[i] : '0;
        end
    end

    // Registered read data and error flag for last cycle's request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_err   <= bus_sel && !dec_ok;
            bus_rdata <= (bus_sel && !bus_wr && dec_ok) ? regs_q[dec_sel] : '0;
        end
    end

    assign data_q  = regs_q[SEL_DATA];
    assign maska_q = regs_q[SEL_MASKA];
    assign maskb_q = regs_q[SEL_MASKB];
    assign dir_q   = regs_q[SEL_DIR];
    assign polar_q = regs_q[SEL_POLAR];
    assign edge_q  = regs_q[SEL_EDGE];
    assign both_q  = regs_q[SEL_BOTH];
    assign inen_q  = regs_q[SEL_INEN];
endmodule

// File: rtl/gpio_rf_regfile_chk.sv
// Property checker for the GPIO register bank, attached by bind.
// Watches ports only; assumes inputs are stable within each cycle.
module gpio_rf_regfile_chk #(
    parameter int AW = 7,
    parameter int W  = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [1:0]    bus_size,
    input logic [W-1:0]  bus_wdata,
    input logic [W-1:0]  bus_rdata,
    input logic          bus_err,
    input logic          pin_we,
    input logic [W-1:0]  pin_in,
    input logic [W-1:0]  data_q,
    input logic [W-1:0]  maska_q,
    input logic [W-1:0]  maskb_q,
    input logic [W-1:0]  dir_q,
    input logic [W-1:0]  polar_q,
    input logic [W-1:0]  edge_q,
    input logic [W-1:0]  both_q,
    input logic [W-1:0]  inen_q
);
    logic bad_req;
    logic good_wr;
    assign bad_req = bus_sel && ((bus_size != 2'b01) || (bus_addr[1:0] != 2'b00)
                                 || (int'(bus_addr) > 'h40));
    assign good_wr = bus_sel && bus_wr && (bus_size == 2'b01);

    // R7
    err_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0));

    // R7
    bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_req |=> bus_err);

    // R7
    bad_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_req |=> ($stable(maska_q) && $stable(maskb_q) && $stable(dir_q)
                     && $stable(polar_q) && $stable(edge_q) && $stable(both_q)
                     && $stable(inen_q)));

    // R4
    maska_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && int'(bus_addr) == 'h18) |=> (maska_q == $past(maska_q | bus_wdata)));

    // R3
    maskb_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && int'(bus_addr) == 'h24) |=> (maskb_q == $past(maskb_q & ~bus_wdata)));

    // R5
    maska_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && int'(bus_addr) == 'h1C) |=> (maska_q == $past(maska_q ^ bus_wdata)));

    // R2
    dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && int'(bus_addr) == 'h30) |=> (dir_q == $past(bus_wdata)));

    // R8
    write_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr) |=> (bus_rdata == '0));
endmodule

bind gpio_rf_regfile gpio_rf_regfile_chk #(.AW(AW), .W(W)) i_chk (.*);

// File: tb/test_gpio_rf_regfile.sv
// Scoreboard bench: the driver keeps a reference model, pushes expected
// items with a due cycle; the monitor pops and compares at falling edges.
module test_gpio_rf_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'b01;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_err;
    logic        pin_we = 1'b0;
    logic [15:0] pin_in = '0;
    logic [15:0] data_q, maska_q, maskb_q, dir_q, polar_q, edge_q, both_q, inen_q;

    gpio_rf_regfile i_gpio_rf_regfile (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .pin_we(pin_we), .pin_in(pin_in),
        .data_q(data_q), .maska_q(maska_q), .maskb_q(maskb_q), .dir_q(dir_q),
        .polar_q(polar_q), .edge_q(edge_q), .both_q(both_q), .inen_q(inen_q)
    );

    always #5 clk = ~clk;   // 100 MHz

    typedef struct {
        int          due;
        int          kind;    // 0: {err,rdata}; 1..8: register port
        logic [16:0] exp;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [15:0] m [8];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [16:0] observe(int kind);
        case (kind)
            0: return {bus_err, bus_rdata};
            1: return {1'b0, data_q};
            2: return {1'b0, maska_q};
            3: return {1'b0, maskb_q};
            4: return {1'b0, dir_q};
            5: return {1'b0, polar_q};
            6: return {1'b0, edge_q};
            7: return {1'b0, both_q};
            default: return {1'b0, inen_q};
        endcase
    endfunction

    // Monitor: compare every due item at the falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            item_t it;
            logic [16:0] act;
            it  = sb_q.pop_front();
            act = observe(it.kind);
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual 0x%05h expected 0x%05h", it.tag, act, it.exp);
            end
        end
    end

    // One bus cycle: drive, update the model, queue the response item.
    task automatic access(input bit sel, input bit wr, input int addr, input logic [1:0] size,
                          input logic [15:0] wdata, input bit pwe, input logic [15:0] pin,
                          input string tag);
        bit          ok;
        int          word, idx, op;
        logic [15:0] nv, tch, pen, rd;
        @(negedge clk); #1;
        bus_sel = sel; bus_wr = wr; bus_addr = 7'(addr); bus_size = size;
        bus_wdata = wdata; pin_we = pwe; pin_in = pin;
        word = addr / 4;
        ok   = (size == 2'b01) && (addr % 4 == 0) && (addr <= 'h40);
        idx  = (word < 12) ? word / 4 : word - 9;
        op   = (word < 12) ? word % 4 : 0;
        rd   = (sel && !wr && ok) ? m[idx] : 16'h0;
        sb_q.push_back('{cyc + 1, 0, {sel && !ok, rd}, tag});
        pen = pwe ? (m[3] & m[7]) : 16'h0;
        nv = 16'h0; tch = 16'h0;
        if (sel && wr && ok) begin
            case (op)
                0: begin nv = wdata;          tch = 16'hFFFF; end
                1: begin nv = m[idx] & ~wdata; tch = wdata; end
                2: begin nv = m[idx] | wdata;  tch = wdata; end
                default: begin nv = m[idx] ^ wdata; tch = wdata; end
            endcase
        end
        if (sel && wr && ok && idx != 0) m[idx] = nv;
        if (!(sel && wr && ok && idx == 0)) tch = 16'h0;
        m[0] = (nv & tch) | (pin & pen & ~tch) | (m[0] & ~tch & ~pen);
    endtask

    task automatic wr16(input int addr, input logic [15:0] d, input string tag);
        access(1, 1, addr, 2'b01, d, 0, 16'h0, tag);
    endtask
    task automatic rd16(input int addr, input string tag);
        access(1, 0, addr, 2'b01, 16'h0, 0, 16'h0, tag);
    endtask
    task automatic idle();
        access(0, 0, 0, 2'b01, 16'h0, 0, 16'h0, "R8 idle");
    endtask
    // Queue a check of a register port against the model (kind = index+1).
    task automatic chk_port(input int idx, input string tag);
        sb_q.push_back('{cyc + 1, idx + 1, {1'b0, m[idx]}, tag});
    endtask
    task automatic chk_all(input string tag);
        for (int i = 0; i < 8; i++) chk_port(i, tag);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m[i] = 16'h0;
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        idle();
        chk_all("R1 reset value");
        // R2 plain writes and read-back
        wr16('h00, 16'hA5C3, "R8 write rdata");
        wr16('h10, 16'h0F0F, "R2 wr maska");
        wr16('h20, 16'hF0F0, "R2 wr maskb");
        wr16('h30, 16'h00FF, "R2 wr dir");
        wr16('h34, 16'h1234, "R2 wr polar");
        wr16('h38, 16'h5678, "R2 wr edge");
        wr16('h3C, 16'h9ABC, "R2 wr both");
        wr16('h40, 16'h0F0F, "R2 wr inen");
        chk_all("R2 plain write");
        for (int a = 'h30; a <= 'h40; a += 4) rd16(a, "R6 plain read");
        // R3 clear aliases
        wr16('h04, 16'h0003, "R3 data clear");
        wr16('h14, 16'h0101, "R3 maska clear");
        wr16('h24, 16'h8001, "R3 maskb clear");
        chk_all("R3 clear alias");
        // R4 set aliases
        wr16('h08, 16'h0300, "R4 data set");
        wr16('h18, 16'hF000, "R4 maska set");
        wr16('h28, 16'h000C, "R4 maskb set");
        chk_all("R4 set alias");
        // R5 toggle aliases
        wr16('h0C, 16'hFF00, "R5 data toggle");
        wr16('h1C, 16'h00FF, "R5 maska toggle");
        wr16('h2C, 16'hFFFF, "R5 maskb toggle");
        chk_all("R5 toggle alias");
        // R6 read every alias of every group
        for (int a = 0; a < 'h30; a += 4) rd16(a, "R6 alias read");
        // R7 invalid requests
        access(1, 1, 'h12, 2'b01, 16'hFFFF, 0, 16'h0, "R7 misaligned write");
        access(1, 1, 'h44, 2'b01, 16'hFFFF, 0, 16'h0, "R7 past map write");
        access(1, 1, 'h10, 2'b10, 16'hFFFF, 0, 16'h0, "R7 wide write");
        access(1, 1, 'h0C, 2'b00, 16'hFFFF, 0, 16'h0, "R7 byte write");
        access(1, 0, 'h7C, 2'b01, 16'h0, 0, 16'h0, "R7 bad read");
        idle();
        chk_all("R7 no change");
        // R9 pin sample alone: enabled bits are dir & inen = 0x000F
        access(0, 0, 0, 2'b01, 16'h0, 1, 16'hFFF5, "R9 pin sample");
        chk_port(0, "R9 pin sample");
        access(0, 0, 0, 2'b01, 16'h0, 1, 16'h000A, "R9 pin sample 2");
        chk_port(0, "R9 pin sample 2");
        // R10 bus write and pin sample in the same cycle
        access(1, 1, 'h08, 2'b01, 16'h0001, 1, 16'h0000, "R10 set vs pin");
        chk_port(0, "R10 set vs pin");
        access(1, 1, 'h04, 2'b01, 16'h0004, 1, 16'hFFFF, "R10 clear vs pin");
        chk_port(0, "R10 clear vs pin");
        access(1, 1, 'h00, 2'b01, 16'h1230, 1, 16'hFFFF, "R10 plain vs pin");
        chk_port(0, "R10 plain vs pin");
        rd16('h0C, "R10 read back");
        // R1 reset again from a non-zero state
        @(negedge clk); #1 rst_n = 1'b0; bus_sel = 1'b0; pin_we = 1'b0;
        for (int i = 0; i < 8; i++) m[i] = 16'h0;
        @(negedge clk); #1 rst_n = 1'b1;
        idle();
        chk_all("R1 re-reset");
        idle();
        idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule